// File: doc/BRIEF.md
# Fractional Hundredths Tick Generator

This block turns a 4096-per-second reference strobe into a 100-per-second tick. An integer prescaler cannot do that, so the block mixes two divide ratios. It divides by 41 for twenty-four output periods in a row and then by 40 for one period. A full cycle of twenty-five periods uses exactly 1024 reference strobes, which is one quarter of a second. Each tick may land a fraction of a reference period away from the ideal 10 ms grid. The error never builds up, and the tick train realigns exactly every 250 ms.

The reference strobe and the oscillator-enable input are both sampled on the system clock. When the oscillator enable is low, the block freezes its position in the pattern and produces no ticks. The synchronous reset restarts the pattern, and so does a separate resynchronise pulse that the surrounding timekeeper raises when software writes the time. After either one, the first tick comes after a full long period of 41 strobes.

Top module: `frac_tick_gen`

## Requirements
- R1: While reset is high no tick is produced, and after reset is released the first tick comes on the 41st accepted strobe.
- R2: Each of the first 24 periods of a cycle spans exactly 41 accepted strobes.
- R3: The 25th period of a cycle spans exactly 40 accepted strobes, and the next period is a 41-strobe period again.
- R4: One full cycle spans 1024 accepted strobes and holds 25 ticks. The tick positions repeat identically from one cycle to the next.
- R5: `tick_o` is high for exactly one system clock cycle. That cycle is one in which `ref_stb_i` and `osc_en_i` are both high, and it is the cycle of the strobe that completes the period.
- R6: A strobe that arrives while `osc_en_i` is low is ignored. It produces no tick and does not advance the pattern, so later ticks keep the same count of accepted strobes.
- R7: A `resync_i` pulse clears the pattern position in the next clock cycle. It has priority over a strobe in the same cycle, and the next tick comes on the 41st accepted strobe after the pulse.
- R8: Over 4096 consecutive accepted strobes the block produces exactly 100 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| resync_i | input | 1 | Restart the pattern, for example on a time write |
| ref_stb_i | input | 1 | Reference strobe, one cycle wide, 4096 per second |
| osc_en_i | input | 1 | Oscillator running; low freezes the generator |
| tick_o | output | 1 | One-cycle hundredths tick |

## Verification
The bench walks the generator through more than six full 1024-strobe cycles. It checks each strobe against the arithmetic tick position: every multiple of 41 up to 984 within a cycle, and 1024. This exposes a wrong long ratio, a wrong short ratio or a misplaced short period. The gaps between strobes vary, including back-to-back strobes, and ordinary cycles are checked for silence, which shows that the tick follows strobe completion and not clock time. Strobes with the enable low are mixed in, and one resynchronise pulse coincides with a strobe. These two cases tell apart a design that counts gated strobes from one that freezes correctly, and a resync that loses to the strobe from one that wins.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
    localparam int DEF_LONG_DIV     = 41;
    localparam int DEF_SHORT_DIV    = 40;
    localparam int DEF_LONG_PERIODS = 24;
endpackage

// File: rtl/tick_sub_counter.sv
module tick_sub_counter #(
    parameter int LONG_DIV  = frac_tick_pkg::DEF_LONG_DIV,
    parameter int SHORT_DIV = frac_tick_pkg::DEF_SHORT_DIV
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic resync_i,
    input  logic step_i,
    input  logic short_sel_i,
    output logic wrap_o
);
    localparam int SUB_W = $clog2(LONG_DIV);
    localparam logic [SUB_W-1:0] LONG_TERM  = SUB_W'(LONG_DIV - 1);
    localparam logic [SUB_W-1:0] SHORT_TERM = SUB_W'(SHORT_DIV - 1);

    typedef struct packed {
        logic [SUB_W-1:0] cnt;
    } sub_state_t;

    sub_state_t st_d, st_q;
    logic [SUB_W-1:0] term;

    always_comb begin
        st_d   = st_q;
        term   = short_sel_i ? SHORT_TERM : LONG_TERM;
        wrap_o = step_i && (st_q.cnt == term);
        if (resync_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            st_d.cnt = wrap_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    // R2: the intra-period count never exceeds the long terminal value
    a_r2_count_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= LONG_TERM);
    // R6: without an accepted strobe the position holds
    a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!step_i && !resync_i) |=> $stable(st_q.cnt));
    // R7: a resync pulse clears the count in the next cycle
    a_r7_resync_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        resync_i |=> (st_q.cnt == '0));
    // R3: during the short period the count stays inside the short range
    a_r3_short_range: assert property (@(posedge clk_i) disable iff (rst_i)
        short_sel_i |-> (st_q.cnt <= SHORT_TERM));
endmodule

// File: rtl/tick_period_counter.sv
module tick_period_counter #(
    parameter int LONG_PERIODS = frac_tick_pkg::DEF_LONG_PERIODS
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic resync_i,
    input  logic advance_i,
    output logic short_sel_o
);
    localparam int PER_W = $clog2(LONG_PERIODS + 1);
    localparam logic [PER_W-1:0] LAST_IDX = PER_W'(LONG_PERIODS);

    typedef struct packed {
        logic [PER_W-1:0] idx;
    } per_state_t;

    per_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        short_sel_o = (st_q.idx == LAST_IDX);
        if (resync_i) begin
            st_d.idx = '0;
        end else if (advance_i) begin
            st_d.idx = short_sel_o ? '0 : st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    // R4: the period index stays within one cycle
    a_r4_index_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.idx <= LAST_IDX);
    // R3: after the short period the cycle restarts
    a_r3_cycle_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (advance_i && !resync_i && st_q.idx == LAST_IDX) |=> (st_q.idx == '0));
    // R2: a completed long period moves to the next index
    a_r2_index_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (advance_i && !resync_i && st_q.idx != LAST_IDX)
        |=> (st_q.idx == $past(st_q.idx) + 1'b1));
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
    parameter int LONG_DIV     = frac_tick_pkg::DEF_LONG_DIV,
    parameter int SHORT_DIV    = frac_tick_pkg::DEF_SHORT_DIV,
    parameter int LONG_PERIODS = frac_tick_pkg::DEF_LONG_PERIODS
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic resync_i,
    input  logic ref_stb_i,
    input  logic osc_en_i,
    output logic tick_o
);
    logic step;
    logic wrap;
    logic short_sel;

    assign step   = ref_stb_i && osc_en_i;
    assign tick_o = wrap;

    tick_sub_counter #(
        .LONG_DIV  (LONG_DIV),
        .SHORT_DIV (SHORT_DIV)
    ) u_sub (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .resync_i    (resync_i),
        .step_i      (step),
        .short_sel_i (short_sel),
        .wrap_o      (wrap)
    );

    tick_period_counter #(
        .LONG_PERIODS (LONG_PERIODS)
    ) u_per (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .resync_i    (resync_i),
        .advance_i   (wrap),
        .short_sel_o (short_sel)
    );

    // R5: two ticks never fall in adjacent cycles
    a_r5_single_cycle_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o);
    // R6: a strobe with the oscillator stopped never ticks
    a_r6_no_tick_when_stopped: assert property (@(posedge clk_i) disable iff (rst_i)
        !osc_en_i |-> !tick_o);
endmodule

// File: tb/tb_frac_tick_gen.sv
module tb_frac_tick_gen;
    logic clk = 1'b0;
    logic rst, resync, ref_stb, osc_en;
    logic tick;
    int   n_checks = 0;
    int   n_fail   = 0;
    int   acc      = 0;
    int   ticks    = 0;
    int   cycles   = 0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;

    frac_tick_gen dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .resync_i (resync),
        .ref_stb_i(ref_stb),
        .osc_en_i (osc_en),
        .tick_o   (tick)
    );

    function automatic bit exp_tick(int n);
        int p = n % 1024;
        return (p == 0) || ((p % 41 == 0) && (p <= 984));
    endfunction

    task automatic check(bit act, bit exp, string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: tick=%0b expected %0b (accepted strobe %0d)", req, act, exp, acc);
        end
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            ref_stb = 1'b0; osc_en = 1'b1; resync = 1'b0;
            #5 check(tick, 1'b0, "R5 idle");
        end
    endtask

    // one strobe; en=0 means a gated strobe
    task automatic strobe(bit en, string req);
        @(negedge clk);
        ref_stb = 1'b1; osc_en = en; resync = 1'b0;
        #5;
        if (en) begin
            acc++;
            check(tick, exp_tick(acc), req);
            if (tick) ticks++;
        end else begin
            check(tick, 1'b0, "R6 gated strobe");
        end
    endtask

    initial begin
        rst = 1'b1; resync = 1'b0; ref_stb = 1'b0; osc_en = 1'b1;
        // R1: strobes during reset give no tick
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            ref_stb = 1'b1;
            #5 check(tick, 1'b0, "R1 in reset");
        end
        @(negedge clk); rst = 1'b0; ref_stb = 1'b0;
        // R1..R4: two full cycles with varied gaps, R6 gated strobes mixed in
        for (int i = 0; i < 2048; i++) begin
            if (i % 7 == 3) strobe(1'b0, "R6");
            strobe(1'b1, (acc % 1024) >= 984 ? "R3" : (acc < 41 ? "R1" : "R2"));
            if (i % 3 != 0) idle(i % 3);
        end
        // R7: run partway, then resync together with a strobe
        for (int i = 0; i < 500; i++) strobe(1'b1, "R4");
        @(negedge clk);
        ref_stb = 1'b1; osc_en = 1'b1; resync = 1'b1;
        #5;
        @(negedge clk);
        resync = 1'b0; ref_stb = 1'b0;
        acc = 0; ticks = 0;
        // R7/R8: four more cycles counted from the resync
        for (int i = 0; i < 4096; i++) begin
            strobe(1'b1, acc < 41 ? "R7" : "R4");
            if (i % 5 == 0) idle(1);
        end
        n_checks++;
        if (ticks != 100) begin
            n_fail++;
            $display("FAIL R8: ticks=%0d expected 100", ticks);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule